// File: doc/BRIEF.md
# Four-Stage Pipeline Hazard Controller

This block is the control logic for an in-order pipeline with four stages: Fetch, Decode, Operate and Write. It keeps its own shadow copy of the descriptor of each instruction in flight. A descriptor holds the source register numbers, the destination register number and the branch kind. The controller decides every cycle whether a new fetch may be taken. It holds Fetch and Decode and sends an empty slot into Operate when an instruction depends on the one just ahead of it. It kills the wrongly fetched instruction when a branch is taken. It also reports the valid bit of every stage and the register write leaving the Write stage.

There is no operand forwarding. A consumer may start Operate only after its producer has finished Write, which costs one idle cycle for adjacent instructions. Fetch timing after a branch depends on the branch kind. After an unconditional branch, fetch resumes once the branch has left Decode. After a conditional branch, a build-time option picks one of two behaviours. In the waiting variant (`COND_SPEC = 0`), fetch stops until the branch has resolved in Operate. In the sequential variant (`COND_SPEC = 1`), fetch keeps going, and a taken result aborts the instruction that followed the branch.

Top module: `hzc_top`

## Requirements
- R1: After reset all stage valid outputs and `wb_en` are low and `fetch_en` is high.
- R2: An independent instruction accepted at fetch in cycle c is in Write in cycle c+3. Back-to-back independent instructions are accepted in consecutive cycles.
- R3: The adjacent-dependency case is when the instruction in Decode names, in any source field, the nonzero destination of the valid instruction in Operate. In that case `dep_stall` and `bubble_o` are high and `fetch_en` is low for exactly one cycle. Decode keeps its contents, Operate receives an invalid slot, and the consumer reaches Write one cycle later than in R2.
- R4: A consumer whose producer is already in Write while the consumer is in Decode causes no stall.
- R5: Register number 0 is never a dependency: neither a destination of 0 nor a matching source of 0 causes a stall.
- R6: Kind encoding of `in_kind` is 0 plain, 1 unconditional branch, 2 conditional branch, 3 treated as plain. With an unconditional branch in Decode, `fetch_en` is low, so the next fetch is accepted two cycles after the branch's own fetch.
- R7: With `COND_SPEC = 0`, `fetch_en` stays low while a conditional branch is in Decode or Operate. The next fetch is accepted three cycles after the branch's fetch, whatever `op_taken` is.
- R8: With `COND_SPEC = 1`, a conditional branch does not hold fetch. When it is in Operate with `op_taken` high, `abort` is high and `fetch_en` is low for that cycle. The Decode stage is then cleared, so the next accepted fetch comes three cycles after the branch's fetch. With `op_taken` low, nothing is aborted.
- R9: An aborted instruction never produces `wb_en`.
- R10: When an abort and an adjacent dependency fall in the same cycle, the abort wins and `dep_stall` stays low.
- R11: `wb_en` is high only for a valid instruction in Write with a nonzero destination, and `wb_dst` gives that destination.
- R12: `vld_f` is high exactly when `in_valid` and `fetch_en` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A descriptor is offered for fetch this cycle |
| in_src | input | NSRC*REG_W | Source register fields, slot 0 in the low bits |
| in_dst | input | REG_W | Destination register, 0 means no write |
| in_kind | input | 2 | Branch kind of the offered instruction |
| op_taken | input | 1 | Branch result of the instruction now in Operate |
| fetch_en | output | 1 | The offered descriptor is accepted this cycle |
| dep_stall | output | 1 | Fetch and Decode held for a dependency |
| bubble_o | output | 1 | An empty slot enters Operate at the next edge |
| abort | output | 1 | The instruction after a taken branch is killed |
| vld_f | output | 1 | Fetch stage valid |
| vld_d | output | 1 | Decode stage valid |
| vld_o | output | 1 | Operate stage valid |
| vld_w | output | 1 | Write stage valid |
| wb_en | output | 1 | Register write this cycle |
| wb_dst | output | REG_W | Register written |

## Verification
The sequential variant can see a dependency stall and a taken-branch abort in the same cycle. The bench provokes this with a conditional branch that has a nonzero destination, followed at once by an instruction that reads that register, while `op_taken` is high. It then judges at the ports that the stall count stays zero, that exactly one abort is seen, and that the consumer never writes. An exhaustive sweep covers every producer destination against every consumer source, in both source slots and at both distances. It checks acceptance cycles and write cycles against values computed from the stage count.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
   typedef enum logic [1:0] {
      KIND_PLAIN = 2'd0,
      KIND_JUMP  = 2'd1,
      KIND_COND  = 2'd2
   } kind_e;
endpackage

// File: rtl/hzc_dep_detect.sv
module hzc_dep_detect #(
   parameter int REG_W = 4,
   parameter int NSRC  = 2
) (
   input  logic                  cons_vld,
   input  logic [NSRC*REG_W-1:0] cons_src,
   input  logic                  prod_vld,
   input  logic [REG_W-1:0]      prod_dst,
   output logic                  hit
);
   localparam logic [REG_W-1:0] NOREG = '0;

   logic [NSRC-1:0] match;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         logic [REG_W-1:0] s;
         assign s        = cons_src[i*REG_W +: REG_W];
         assign match[i] = (s != NOREG) && (s == prod_dst);
      end
   endgenerate

   assign hit = cons_vld && prod_vld && (prod_dst != NOREG) && (|match);
endmodule

// File: rtl/hzc_fetch_gate.sv
module hzc_fetch_gate
   import hzc_pkg::*;
#(
   parameter bit COND_SPEC = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       d_vld,
   input  logic [1:0] d_kind,
   input  logic       o_vld,
   input  logic [1:0] o_kind,
   input  logic       op_taken,
   input  logic       dep_hit,
   output logic       fetch_en,
   output logic       dep_stall,
   output logic       abort
);
   logic jump_hold;
   logic cond_hold;

   assign jump_hold = d_vld && (d_kind == KIND_JUMP);

   generate
      if (COND_SPEC) begin : g_seq
         assign cond_hold = 1'b0;
         assign abort     = o_vld && (o_kind == KIND_COND) && op_taken;
      end else begin : g_wait
         assign cond_hold = (d_vld && (d_kind == KIND_COND)) ||
                            (o_vld && (o_kind == KIND_COND));
         assign abort     = 1'b0;

         // R7
         cond_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (o_vld && (o_kind == KIND_COND)) |=> !d_vld);
      end
   endgenerate

   assign dep_stall = dep_hit && !abort;
   assign fetch_en  = !(dep_stall || abort || jump_hold || cond_hold);

   // R6
   jump_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_vld && (d_kind == KIND_JUMP) && !dep_stall) |=> !d_vld);
endmodule

// File: rtl/hzc_stage_regs.sv
module hzc_stage_regs #(
   parameter int REG_W = 4,
   parameter int NSRC  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  f_vld,
   input  logic [NSRC*REG_W-1:0] f_src,
   input  logic [REG_W-1:0]      f_dst,
   input  logic [1:0]            f_kind,
   input  logic                  dep_stall,
   input  logic                  abort,
   output logic                  d_vld,
   output logic [NSRC*REG_W-1:0] d_src,
   output logic [REG_W-1:0]      d_dst,
   output logic [1:0]            d_kind,
   output logic                  o_vld,
   output logic [REG_W-1:0]      o_dst,
   output logic [1:0]            o_kind,
   output logic                  w_vld,
   output logic [REG_W-1:0]      w_dst
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         d_vld  <= 1'b0;
         d_src  <= '0;
         d_dst  <= '0;
         d_kind <= '0;
      end else if (abort) begin
         d_vld  <= 1'b0;
      end else if (!dep_stall) begin
         d_vld  <= f_vld;
         d_src  <= f_src;
         d_dst  <= f_dst;
         d_kind <= f_kind;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_vld  <= 1'b0;
         o_dst  <= '0;
         o_kind <= '0;
         w_vld  <= 1'b0;
         w_dst  <= '0;
      end else begin
         o_vld  <= d_vld && !dep_stall && !abort;
         o_dst  <= d_dst;
         o_kind <= d_kind;
         w_vld  <= o_vld;
         w_dst  <= o_dst;
      end
   end

   // R3
   bubble_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dep_stall |=> !o_vld);

   // R3
   hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dep_stall |=> (d_vld && $stable(d_src) && $stable(d_dst)));

   // R8
   abort_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!d_vld && !o_vld));

   // R9
   abort_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> ##1 !w_vld);
endmodule

// File: rtl/hzc_top.sv
module hzc_top
   import hzc_pkg::*;
#(
   parameter int REG_W     = 4,
   parameter int NSRC      = 2,
   parameter bit COND_SPEC = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [NSRC*REG_W-1:0] in_src,
   input  logic [REG_W-1:0]      in_dst,
   input  logic [1:0]            in_kind,
   input  logic                  op_taken,
   output logic                  fetch_en,
   output logic                  dep_stall,
   output logic                  bubble_o,
   output logic                  abort,
   output logic                  vld_f,
   output logic                  vld_d,
   output logic                  vld_o,
   output logic                  vld_w,
   output logic                  wb_en,
   output logic [REG_W-1:0]      wb_dst
);
   localparam int SRC_BITS = NSRC * REG_W;

   generate
      if (REG_W < 2) begin : g_bad_w
         $error("hzc_top: REG_W must be at least 2");
      end
      if (NSRC < 1) begin : g_bad_n
         $error("hzc_top: NSRC must be at least 1");
      end
   endgenerate

   logic [SRC_BITS-1:0] d_src;
   logic [REG_W-1:0]    d_dst, o_dst, w_dst;
   logic [1:0]          d_kind, o_kind;
   logic                d_vld, o_vld, w_vld;
   logic                dep_hit;

   assign vld_f = in_valid && fetch_en;

   hzc_dep_detect #(.REG_W(REG_W), .NSRC(NSRC)) u_dep (
      .cons_vld (d_vld),
      .cons_src (d_src),
      .prod_vld (o_vld),
      .prod_dst (o_dst),
      .hit      (dep_hit)
   );

   hzc_fetch_gate #(.COND_SPEC(COND_SPEC)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .d_vld     (d_vld),
      .d_kind    (d_kind),
      .o_vld     (o_vld),
      .o_kind    (o_kind),
      .op_taken  (op_taken),
      .dep_hit   (dep_hit),
      .fetch_en  (fetch_en),
      .dep_stall (dep_stall),
      .abort     (abort)
   );

   hzc_stage_regs #(.REG_W(REG_W), .NSRC(NSRC)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .f_vld     (vld_f),
      .f_src     (in_src),
      .f_dst     (in_dst),
      .f_kind    (in_kind),
      .dep_stall (dep_stall),
      .abort     (abort),
      .d_vld     (d_vld),
      .d_src     (d_src),
      .d_dst     (d_dst),
      .d_kind    (d_kind),
      .o_vld     (o_vld),
      .o_dst     (o_dst),
      .o_kind    (o_kind),
      .w_vld     (w_vld),
      .w_dst     (w_dst)
   );

   assign bubble_o = dep_stall;
   assign vld_d    = d_vld;
   assign vld_o    = o_vld;
   assign vld_w    = w_vld;
   assign wb_en    = w_vld && (w_dst != '0);
   assign wb_dst   = w_dst;

   // R11
   wb_follows_operate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> $past(o_vld));
endmodule

// File: tb/hzc_top_test.sv
module hzc_top_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_src = '0;
   logic [3:0] in_dst = '0;
   logic [1:0] in_kind = '0;
   logic       op_taken = 1'b0;
   bit         sel = 1'b0;

   logic fe0, st0, bb0, ab0, vf0, vd0, vo0, vw0, we0;
   logic fe1, st1, bb1, ab1, vf1, vd1, vo1, vw1, we1;
   logic [3:0] wd0, wd1;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int stall_cnt = 0;
   int abort_cnt = 0;
   int wb_at [16];
   bit done = 1'b0;

   always #5 clk = ~clk;

   hzc_top #(.REG_W(4), .NSRC(2), .COND_SPEC(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src),
      .in_dst(in_dst), .in_kind(in_kind), .op_taken(op_taken),
      .fetch_en(fe0), .dep_stall(st0), .bubble_o(bb0), .abort(ab0),
      .vld_f(vf0), .vld_d(vd0), .vld_o(vo0), .vld_w(vw0),
      .wb_en(we0), .wb_dst(wd0));

   hzc_top #(.REG_W(4), .NSRC(2), .COND_SPEC(1'b1)) uut_spec (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src),
      .in_dst(in_dst), .in_kind(in_kind), .op_taken(op_taken),
      .fetch_en(fe1), .dep_stall(st1), .bubble_o(bb1), .abort(ab1),
      .vld_f(vf1), .vld_d(vd1), .vld_o(vo1), .vld_w(vw1),
      .wb_en(we1), .wb_dst(wd1));

   wire       fe  = sel ? fe1 : fe0;
   wire       stl = sel ? st1 : st0;
   wire       abt = sel ? ab1 : ab0;
   wire       vf  = sel ? vf1 : vf0;
   wire       wbe = sel ? we1 : we0;
   wire [3:0] wbd = sel ? wd1 : wd0;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         if (wbe) wb_at[wbd] = cyc;
         if (stl) stall_cnt++;
         if (abt) abort_cnt++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_log();
      for (int i = 0; i < 16; i++) wb_at[i] = -1;
      stall_cnt = 0;
      abort_cnt = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         in_valid = 1'b0;
         #1;
         // R12: no offer, no fetch-stage valid
         chk(vf == 1'b0, "R12 idle vld_f", int'(vf), 0);
      end
   endtask

   task automatic issue(input logic [3:0] sa, input logic [3:0] sb,
                        input logic [3:0] d, input logic [1:0] k,
                        output int acc);
      @(negedge clk);
      in_valid = 1'b1;
      in_src   = {sb, sa};
      in_dst   = d;
      in_kind  = k;
      #1;
      while (!fe) begin
         @(negedge clk);
         #1;
      end
      acc = cyc;
      // R12: accepted offer shows as fetch-stage valid
      chk(vf == 1'b1, "R12 accept vld_f", int'(vf), 1);
      @(posedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int a, b, c, d2, expst;
      string tag;
      clear_log();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(!vd0 && !vo0 && !vw0 && !we0, "R1 valids low", int'({vd0, vo0, vw0, we0}), 0);
      chk(!vd1 && !vo1 && !vw1 && !we1, "R1 valids low seq", int'({vd1, vo1, vw1, we1}), 0);
      chk(fe0 && fe1, "R1 fetch_en", int'({fe0, fe1}), 3);
      rst_n = 1'b1;

      // sweep: producer dst x consumer src x slot x distance
      sel = 1'b0;
      for (int p = 0; p < 16; p++) begin
         for (int s = 0; s < 16; s++) begin
            for (int slot = 0; slot < 2; slot++) begin
               for (int gap = 0; gap < 2; gap++) begin
                  clear_log();
                  d2 = (p == 15) ? 14 : 15;
                  issue(4'd0, 4'd0, 4'(p), 2'd0, a);
                  if (gap != 0) idle(1);
                  if (slot == 0) issue(4'(s), 4'd0, 4'(d2), 2'd0, b);
                  else           issue(4'd0, 4'(s), 4'(d2), 2'd0, b);
                  idle(6);
                  expst = (gap == 0 && p == s && p != 0) ? 1 : 0;
                  if (gap != 0)                tag = "R4";
                  else if (p == 0 || s == 0)   tag = "R5";
                  else if (p == s)             tag = "R3";
                  else                         tag = "R2";
                  chk(b == a + 1 + gap, {tag, " accept"}, b - a, 1 + gap);
                  chk(stall_cnt == expst, {tag, " stalls"}, stall_cnt, expst);
                  chk(wb_at[d2] == b + 3 + expst, {tag, " write cycle"},
                      wb_at[d2] - b, 3 + expst);
                  if (p == 0)
                     chk(wb_at[0] == -1, "R11 dst0 no write", wb_at[0], -1);
                  else if (p != 15)
                     chk(wb_at[p] == a + 3, "R11 producer write", wb_at[p] - a, 3);
               end
            end
         end
      end

      // R6 unconditional branch in both variants
      for (int m = 0; m < 2; m++) begin
         sel = m[0];
         clear_log();
         issue(4'd0, 4'd0, 4'd0, 2'd1, a);
         issue(4'd0, 4'd0, 4'd5, 2'd0, b);
         idle(6);
         chk(b == a + 2, "R6 fetch after jump", b - a, 2);
         chk(wb_at[5] == b + 3, "R6 target write", wb_at[5] - b, 3);
      end

      // R7 waiting variant, taken and not taken
      sel = 1'b0;
      for (int t = 0; t < 2; t++) begin
         op_taken = t[0];
         clear_log();
         issue(4'd0, 4'd0, 4'd0, 2'd2, a);
         issue(4'd0, 4'd0, 4'd6, 2'd0, b);
         idle(6);
         chk(b == a + 3, "R7 fetch after cond", b - a, 3);
         chk(abort_cnt == 0, "R7 no abort", abort_cnt, 0);
         chk(wb_at[6] == b + 3, "R7 write", wb_at[6] - b, 3);
      end

      // R8 / R9 sequential variant
      sel = 1'b1;
      for (int t = 0; t < 2; t++) begin
         op_taken = t[0];
         clear_log();
         issue(4'd0, 4'd0, 4'd0, 2'd2, a);
         issue(4'd0, 4'd0, 4'd7, 2'd0, b);
         issue(4'd0, 4'd0, 4'd8, 2'd0, c);
         idle(6);
         chk(b == a + 1, "R8 no hold on cond", b - a, 1);
         chk(c == a + 2 + t, "R8 fetch after resolve", c - a, 2 + t);
         chk(abort_cnt == t, "R8 abort count", abort_cnt, t);
         if (t == 1)
            chk(wb_at[7] == -1, "R9 aborted no write", wb_at[7], -1);
         else
            chk(wb_at[7] == b + 3, "R8 kept write", wb_at[7] - b, 3);
         chk(wb_at[8] == c + 3, "R8 later write", wb_at[8] - c, 3);
      end

      // R10 abort and dependency in the same cycle
      op_taken = 1'b1;
      clear_log();
      issue(4'd0, 4'd0, 4'd9, 2'd2, a);
      issue(4'd9, 4'd0, 4'd10, 2'd0, b);
      issue(4'd0, 4'd0, 4'd11, 2'd0, c);
      idle(6);
      chk(stall_cnt == 0, "R10 no stall", stall_cnt, 0);
      chk(abort_cnt == 1, "R10 one abort", abort_cnt, 1);
      chk(wb_at[10] == -1, "R10 consumer killed", wb_at[10], -1);
      chk(c == a + 3, "R10 resume", c - a, 3);
      chk(wb_at[9] == a + 3, "R11 branch dst write", wb_at[9] - a, 3);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule